// File: doc/BRIEF.md
# Cycle-Timed Multi-Source Event Scheduler

This block keeps twelve timed events, one per requesting source. Each event holds a start timestamp and a delay, both in clock cycles, together with a pending flag. A free-running cycle counter advances on every clock. A requester arms a source by writing its start and delay, which also sets the source's pending flag. Whenever the check strobe is raised, every pending source is tested. A source is due once the cycles elapsed since its start, taken modulo 2^32, reach its delay.

A due source loses its pending flag and produces a single-cycle pulse on its fire bit. All sources that are due in the same check fire together. A priority encoder reports the lowest-numbered fired source, so downstream logic can service them in the fixed source order. The events are numbered in this order:

| Index | Source |
|---|---|
| 0 | serial link |
| 1 | disc command |
| 2 | disc read |
| 3 | graphics DMA |
| 4 | decoder output DMA |
| 5 | sound DMA |
| 6 | decoder input DMA |
| 7 | ordering-table DMA |
| 8 | disc DMA |
| 9 | lid/seek |
| 10 | line interrupt |
| 11 | sound update |

Top module: `sched_event_top`

## Requirements
- R1: While reset is held, `cycle_count` is 0 and `pending` and `fire` are all zero. `fire_any` is 0 and `fire_first` is 0.
- R2: `cycle_count` increases by exactly one per clock and wraps from 2^32-1 to 0.
- R3: A clock with `arm_en` high and `arm_idx` below 12 sets `pending[arm_idx]` from the next cycle on.
- R4: A check clock (`check_en` high) tests every pending source against the `cycle_count` value in that same clock. A pending source with (`cycle_count` - start) mod 2^32 >= delay fires. Its `fire` bit is 1 in the following cycle, and in that same cycle its `pending` bit has already dropped to 0.
- R5: In a check, a pending source that is not yet due produces no fire bit and stays pending.
- R6: The elapsed-time test is wraparound-safe. A start value numerically above the current count counts as lying in the past, and fires once the wrapped difference reaches the delay.
- R7: All sources due in one check fire in the same cycle, as a multi-bit `fire` vector.
- R8: `fire_any` is the OR of `fire`. `fire_first` is the lowest index whose `fire` bit is set, so index 0 (serial link) has the highest priority and index 11 (sound update) the lowest.
- R9: Arming a source that is already pending replaces its start and delay. Later checks use only the new values.
- R10: If a source is armed in the same clock as a check that would find it due, the arm wins. The source does not fire and stays pending with the new values.
- R11: Without `check_en`, nothing fires and every pending flag is kept.
- R12: Each fire bit is high for exactly one cycle per due detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_en | input | 1 | Arm request this cycle |
| arm_idx | input | 4 | Source index to arm (0..11) |
| arm_start | input | 32 | Start timestamp for the armed source |
| arm_delay | input | 32 | Delay in cycles for the armed source |
| check_en | input | 1 | Check strobe: test pending sources this cycle |
| cycle_count | output | 32 | Free-running cycle counter |
| pending | output | 12 | Pending flag per source |
| fire | output | 12 | One-cycle fire pulse per source |
| fire_any | output | 1 | At least one source fired |
| fire_first | output | 4 | Lowest-index fired source |

## Verification
The properties assume that `arm_idx` stays below twelve whenever `arm_en` is high. The pending-set property only reasons about in-range indices. They also assume that every input is a known value after reset. The stimulus meets both assumptions: it arms only the defined sources, and it drives each control from a quiet zero state, changing inputs only between clock edges. Start values are taken from the visible counter plus chosen offsets. This lets the bench predict the elapsed time, including the wrapped case, without looking inside the design.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int NSRC = 12;
    localparam int CW   = 32;
    localparam int IW   = $clog2(NSRC);

    typedef enum logic [IW-1:0] {
        SRC_SERIAL   = 4'd0,
        SRC_DISC_CMD = 4'd1,
        SRC_DISC_RD  = 4'd2,
        SRC_GFX_DMA  = 4'd3,
        SRC_DEC_OUT  = 4'd4,
        SRC_SND_DMA  = 4'd5,
        SRC_DEC_IN   = 4'd6,
        SRC_OT_DMA   = 4'd7,
        SRC_DISC_DMA = 4'd8,
        SRC_LID_SEEK = 4'd9,
        SRC_LINE_IRQ = 4'd10,
        SRC_SND_UPD  = 4'd11
    } src_e;

    typedef struct packed {
        logic [CW-1:0]            count;
        logic [NSRC-1:0]          pending;
        logic [NSRC-1:0][CW-1:0]  start;
        logic [NSRC-1:0][CW-1:0]  delay;
        logic [NSRC-1:0]          fire;
        logic                     any;
        logic [IW-1:0]            first;
    } sched_state_t;
endpackage

// File: rtl/sched_due_cmp.sv
module sched_due_cmp #(
    parameter int CW = 32
) (
    input  logic [CW-1:0] now,
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] delay,
    input  logic          armed,
    output logic          due
);
    logic [CW-1:0] elapsed;
    // modular subtraction keeps the test valid across counter wrap
    assign elapsed = now - start;
    assign due     = armed && (elapsed >= delay);
endmodule

// File: rtl/sched_prio_enc.sv
module sched_prio_enc #(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        // scan downward so the lowest set index is the one left in idx
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sched_event_top.sv
module sched_event_top
    import sched_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm_en,
    input  logic [IW-1:0]        arm_idx,
    input  logic [CW-1:0]        arm_start,
    input  logic [CW-1:0]        arm_delay,
    input  logic                 check_en,
    output logic [CW-1:0]        cycle_count,
    output logic [NSRC-1:0]      pending,
    output logic [NSRC-1:0]      fire,
    output logic                 fire_any,
    output logic [IW-1:0]        fire_first
);
    sched_state_t s_q, s_d;

    logic [NSRC-1:0] due_vec;
    logic [NSRC-1:0] arm_mask;
    logic [NSRC-1:0] fire_nx;
    logic            enc_any;
    logic [IW-1:0]   enc_idx;
    logic            arm_ok;

    assign arm_ok = arm_en && (arm_idx < IW'(NSRC));

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            sched_due_cmp #(.CW(CW)) u_cmp (
                .now   (s_q.count),
                .start (s_q.start[g]),
                .delay (s_q.delay[g]),
                .armed (s_q.pending[g]),
                .due   (due_vec[g])
            );
            assign arm_mask[g] = arm_ok && (arm_idx == IW'(g));
        end
    endgenerate

    // the check is skipped entirely when nothing is pending; an arm
    // landing on a due source in the same cycle suppresses its fire
    assign fire_nx = (check_en && (|s_q.pending)) ? (due_vec & ~arm_mask) : '0;

    sched_prio_enc #(.N(NSRC), .IW(IW)) u_enc (
        .req (fire_nx),
        .any (enc_any),
        .idx (enc_idx)
    );

    always_comb begin
        s_d       = s_q;
        s_d.count = s_q.count + 1'b1;
        s_d.fire  = fire_nx;
        s_d.any   = enc_any;
        s_d.first = enc_idx;
        // clear before fire: pending drops in the same edge the pulse rises
        s_d.pending = s_q.pending & ~fire_nx;
        if (arm_ok) begin
            s_d.pending[arm_idx] = 1'b1;
            s_d.start[arm_idx]   = arm_start;
            s_d.delay[arm_idx]   = arm_delay;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cycle_count = s_q.count;
    assign pending     = s_q.pending;
    assign fire        = s_q.fire;
    assign fire_any    = s_q.any;
    assign fire_first  = s_q.first;
endmodule

// File: rtl/sched_event_chk.sv
module sched_event_chk
    import sched_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            arm_en,
    input logic [IW-1:0]   arm_idx,
    input logic            check_en,
    input logic [CW-1:0]   cycle_count,
    input logic [NSRC-1:0] pending,
    input logic [NSRC-1:0] fire,
    input logic            fire_any,
    input logic [IW-1:0]   fire_first
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cycle_count == $past(cycle_count) + 1'b1);

    assert_arm_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_en && arm_idx < IW'(NSRC)) |=> pending[$past(arm_idx)]);

    assert_clear_before_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire & pending) == '0);

    assert_fire_was_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fire & ~$past(pending)) == '0);

    assert_first_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_any |-> fire[fire_first] && ((fire & ((NSRC'(1) << fire_first) - 1'b1)) == '0));

    assert_any_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_any == (fire != '0));

    assert_no_check_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !check_en |=> fire == '0);

    assert_pulse_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fire != '0) |=> (fire & $past(fire)) == '0);
endmodule

bind sched_event_top sched_event_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_en      (arm_en),
    .arm_idx     (arm_idx),
    .check_en    (check_en),
    .cycle_count (cycle_count),
    .pending     (pending),
    .fire        (fire),
    .fire_any    (fire_any),
    .fire_first  (fire_first)
);

// File: tb/sched_event_top_tb.sv
module sched_event_top_tb_top;
    import sched_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            arm_en = 1'b0;
    logic [IW-1:0]   arm_idx = '0;
    logic [CW-1:0]   arm_start = '0;
    logic [CW-1:0]   arm_delay = '0;
    logic            check_en = 1'b0;
    logic [CW-1:0]   cycle_count;
    logic [NSRC-1:0] pending;
    logic [NSRC-1:0] fire;
    logic            fire_any;
    logic [IW-1:0]   fire_first;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sched_event_top dut_i (
        .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .arm_idx(arm_idx),
        .arm_start(arm_start), .arm_delay(arm_delay), .check_en(check_en),
        .cycle_count(cycle_count), .pending(pending), .fire(fire),
        .fire_any(fire_any), .fire_first(fire_first)
    );

    // {source, delay, idle cycles between arm and check}
    typedef struct packed {
        logic [3:0]  src;
        logic [31:0] dly;
        logic [7:0]  gap;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  32'd0,   8'd0},
        '{4'd1,  32'd5,   8'd3},
        '{4'd2,  32'd5,   8'd4},
        '{4'd4,  32'd20,  8'd10},
        '{4'd5,  32'd12,  8'd11},
        '{4'd7,  32'd1,   8'd0},
        '{4'd9,  32'd100, 8'd50},
        '{4'd10, 32'd3,   8'd2}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic arm(input int idx, input logic [31:0] st, input logic [31:0] dl);
        arm_en = 1'b1; arm_idx = IW'(idx); arm_start = st; arm_delay = dl;
        @(negedge clk);
        arm_en = 1'b0;
    endtask

    task automatic do_check();
        check_en = 1'b1;
        @(negedge clk);
        check_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flush(input int idx);
        arm(idx, cycle_count, 32'd0);
        do_check();
        idle(1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] c0, c1;
        bit due;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cycle_count == 0 && pending == 0 && fire == 0 && !fire_any && fire_first == 0,
              "R1", {cycle_count, 20'd0, pending}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 counter advance
        c0 = cycle_count;
        idle(5);
        check(cycle_count - c0 == 5, "R2", 64'(cycle_count - c0), 64'd5);

        // table walk: R3 R4 R5 R12
        for (int v = 0; v < NVEC; v++) begin
            c0 = cycle_count;
            arm(int'(VECS[v].src), c0, VECS[v].dly);
            check(pending[VECS[v].src] == 1'b1, "R3", 64'(pending), 64'(1) << VECS[v].src);
            idle(int'(VECS[v].gap));
            c1 = cycle_count;
            do_check();
            due = (c1 - c0) >= VECS[v].dly;
            check(fire == (due ? (NSRC'(1) << VECS[v].src) : '0), due ? "R4" : "R5",
                  64'(fire), due ? (64'(1) << VECS[v].src) : 64'd0);
            check(pending[VECS[v].src] == !due, due ? "R4" : "R5",
                  64'(pending[VECS[v].src]), 64'(!due));
            idle(1);
            check(fire == 0, "R12", 64'(fire), 64'd0);
            if (!due) flush(int'(VECS[v].src));
        end

        // R6 wrapped start: start lies 256 cycles in the past across zero
        c0 = cycle_count - 32'd256;
        arm(3, c0, 32'd200);
        do_check();
        check(fire == 12'h008, "R6", 64'(fire), 64'h008);
        idle(1);
        arm(3, cycle_count - 32'd256, 32'd1000);
        do_check();
        check(fire == 0 && pending[3], "R6", 64'(fire), 64'd0);
        flush(3);

        // R7 + R8 simultaneous fire, lowest index reported
        arm(11, cycle_count, 32'd0);
        arm(3, cycle_count, 32'd0);
        arm(6, cycle_count, 32'd0);
        do_check();
        check(fire == 12'h848, "R7", 64'(fire), 64'h848);
        check(fire_any && fire_first == 4'd3, "R8", 64'(fire_first), 64'd3);
        check(pending == 0, "R4", 64'(pending), 64'd0);
        idle(1);
        check(!fire_any && fire == 0, "R12", 64'(fire), 64'd0);

        // R9 re-arm overwrites start and delay
        arm(6, cycle_count, 32'd0);
        arm(6, cycle_count, 32'd1000);
        do_check();
        check(fire == 0 && pending[6], "R9", 64'(fire), 64'd0);
        arm(6, cycle_count, 32'd0);
        do_check();
        check(fire == 12'h040, "R9", 64'(fire), 64'h040);
        idle(1);

        // R10 arm collides with a check that finds the source due
        arm(8, cycle_count, 32'd0);
        arm_en = 1'b1; arm_idx = 4'd8; arm_start = cycle_count; arm_delay = 32'd0;
        check_en = 1'b1;
        @(negedge clk);
        arm_en = 1'b0; check_en = 1'b0;
        check(fire == 0 && pending[8], "R10", 64'(fire), 64'd0);
        do_check();
        check(fire == 12'h100, "R10", 64'(fire), 64'h100);
        idle(1);

        // R11 no strobe, nothing fires, pending kept
        arm(0, cycle_count, 32'd0);
        idle(6);
        check(fire == 0 && pending == 12'h001, "R11", 64'(pending), 64'h001);
        do_check();
        check(fire == 12'h001 && fire_first == 0, "R11", 64'(fire), 64'h001);
        idle(1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule